// File: doc/BRIEF.md
# Peripheral Window Address Decoder

This block watches the address and strobe lines of an 8-bit processor with a 16-bit address space. It claims one 16-byte window of the memory map for a small peripheral port. It finds the window by comparing the upper twelve address bits against a fixed pattern of ones and zeros. The four lowest bits play no part in that comparison. While the window is addressed, the read and write strobes are withheld from main memory and handed to the peripheral side instead. Outside the window, main memory sees the processor's strobes exactly as issued.

Inside the window, address bits 3:2 pick one of four peripheral functions through active-low selects, and bits 1:0 pass straight through as a register index within that function. The same decode drives the controls of the shared bidirectional data buffer. The buffer is enabled only while a strobe is active inside the window. It points toward the processor when the measurement function is addressed, and away from the processor for every other function. All outputs are combinational.

Top module: `periph_window_decoder`

## Requirements
- R1: An address from 0x3CC0 to 0x3CCF inclusive is a window hit. No other address is a hit.
- R2: Inverting any single bit among address bits 15:4 of a window address removes the hit.
- R3: Outside the window, `mem_rd_n` equals `cpu_rd_n` and `mem_wr_n` equals `cpu_wr_n`.
- R4: On a window hit, `mem_rd_n` and `mem_wr_n` are held high, whatever the processor strobes do.
- R5: On a hit, `per_rd_n` and `per_wr_n` follow `cpu_rd_n` and `cpu_wr_n`. Outside the window, both are held high.
- R6: On a hit, exactly one bit of `sel_n` is low: bit k, where k is address bits 3:2. Bit 0 is the measurement (ADC) function, bit 1 is the first DAC, bit 2 is the second DAC and bit 3 is the switch. Outside the window, all bits of `sel_n` are high.
- R7: `per_reg` always equals address bits 1:0.
- R8: `buf_oe_n` is low only on a hit while `cpu_rd_n` or `cpu_wr_n` is low. Otherwise it is high.
- R9: `buf_to_cpu` is 1 only on a hit with address bits 3:2 equal to 00. Otherwise it is 0.
- R10: When read and write are both low on a hit, both peripheral strobes are low, both memory strobes stay high and the buffer is enabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| cpu_addr | input | 16 | Processor address bus |
| cpu_rd_n | input | 1 | Processor read strobe, active low |
| cpu_wr_n | input | 1 | Processor write strobe, active low |
| mem_rd_n | output | 1 | Read strobe to main memory, active low |
| mem_wr_n | output | 1 | Write strobe to main memory, active low |
| per_rd_n | output | 1 | Read strobe to the peripheral port, active low |
| per_wr_n | output | 1 | Write strobe to the peripheral port, active low |
| sel_n | output | 4 | Function selects, active low, indexed by address bits 3:2 |
| per_reg | output | 2 | Register index inside the selected function |
| buf_oe_n | output | 1 | Data buffer enable, active low |
| buf_to_cpu | output | 1 | Data buffer direction, 1 = toward the processor |

## Verification
Two functions can land in the same cycle: redirection of the read strobe and redirection of the write strobe. The bench provokes this by driving both strobes low together on window addresses and on addresses outside the window. Both cases appear in a full sweep of the address space with all four strobe combinations, and in a dedicated phase. The behavioural model judges each cycle from the address range alone: both peripheral strobes low with memory untouched inside the window, both memory strobes low with the peripheral untouched outside it, and the buffer enable and direction still set by the window and the function code.

// File: rtl/periph_window_pkg.sv
package periph_window_pkg;

    localparam int ADDR_W   = 16;
    localparam int REG_W    = 2;
    localparam int FUNC_W   = 2;
    localparam int NUM_FUNC = 1 << FUNC_W;
    localparam int WIN_LSB  = REG_W + FUNC_W;
    localparam int MATCH_W  = ADDR_W - WIN_LSB;

    localparam logic [ADDR_W-1:0] WIN_BASE = 16'h3CC0;

    typedef enum logic [FUNC_W-1:0] {
        FN_MEASURE = 2'd0,
        FN_DAC_A   = 2'd1,
        FN_DAC_B   = 2'd2,
        FN_SWITCH  = 2'd3
    } func_e;

    typedef struct packed {
        logic rd_n;
        logic wr_n;
    } strobe_t;

    typedef struct packed {
        logic              hit;
        func_e             func;
        logic [REG_W-1:0]  reg_sel;
    } decode_t;

    localparam strobe_t STROBE_IDLE = '{rd_n: 1'b1, wr_n: 1'b1};

    function automatic logic strobe_active(strobe_t s);
        return (!s.rd_n) || (!s.wr_n);
    endfunction

endpackage

// File: rtl/window_match.sv
module window_match
    import periph_window_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output decode_t           dec
);
    logic [MATCH_W-1:0] bit_ok;

    for (genvar b = 0; b < MATCH_W; b++) begin : g_bit
        assign bit_ok[b] = (addr[WIN_LSB + b] == WIN_BASE[WIN_LSB + b]);
    end

    always_comb begin
        dec.hit     = &bit_ok;
        dec.func    = func_e'(addr[WIN_LSB-1:REG_W]);
        dec.reg_sel = addr[REG_W-1:0];
    end
endmodule

// File: rtl/func_select.sv
module func_select
    import periph_window_pkg::*;
(
    input  decode_t             dec,
    output logic [NUM_FUNC-1:0] sel_n
);
    for (genvar k = 0; k < NUM_FUNC; k++) begin : g_sel
        assign sel_n[k] = !(dec.hit && (dec.func == func_e'(k)));
    end

    always_comb begin
        if (!dec.hit) begin
            assert_idle_outside_R6: assert (&sel_n)
                else $error("select active outside window");
        end else begin
            assert_single_select_R6: assert ($countones(~sel_n) == 1)
                else $error("select count wrong inside window");
        end
    end
endmodule

// File: rtl/strobe_router.sv
module strobe_router
    import periph_window_pkg::*;
(
    input  logic    hit,
    input  strobe_t cpu,
    output strobe_t mem,
    output strobe_t per
);
    always_comb begin
        if (hit) begin
            mem = STROBE_IDLE;
            per = cpu;
        end else begin
            mem = cpu;
            per = STROBE_IDLE;
        end
    end

    always_comb begin
        assert_rd_exclusive_R4: assert (mem.rd_n || per.rd_n)
            else $error("read reaches memory and peripheral together");
        assert_wr_exclusive_R5: assert (mem.wr_n || per.wr_n)
            else $error("write reaches memory and peripheral together");
    end
endmodule

// File: rtl/buffer_ctrl.sv
module buffer_ctrl
    import periph_window_pkg::*;
(
    input  decode_t dec,
    input  strobe_t per,
    output logic    oe_n,
    output logic    to_cpu
);
    always_comb begin
        oe_n   = !(dec.hit && strobe_active(per));
        to_cpu = dec.hit && (dec.func == FN_MEASURE);
    end
endmodule

// File: rtl/periph_window_decoder.sv
module periph_window_decoder
    import periph_window_pkg::*;
(
    input  logic [ADDR_W-1:0]   cpu_addr,
    input  logic                cpu_rd_n,
    input  logic                cpu_wr_n,
    output logic                mem_rd_n,
    output logic                mem_wr_n,
    output logic                per_rd_n,
    output logic                per_wr_n,
    output logic [NUM_FUNC-1:0] sel_n,
    output logic [REG_W-1:0]    per_reg,
    output logic                buf_oe_n,
    output logic                buf_to_cpu
);
    decode_t dec;
    strobe_t cpu_s, mem_s, per_s;

    assign cpu_s = '{rd_n: cpu_rd_n, wr_n: cpu_wr_n};

    window_match u_match (
        .addr (cpu_addr),
        .dec  (dec)
    );

    func_select u_sel (
        .dec   (dec),
        .sel_n (sel_n)
    );

    strobe_router u_route (
        .hit (dec.hit),
        .cpu (cpu_s),
        .mem (mem_s),
        .per (per_s)
    );

    buffer_ctrl u_buf (
        .dec    (dec),
        .per    (per_s),
        .oe_n   (buf_oe_n),
        .to_cpu (buf_to_cpu)
    );

    assign mem_rd_n = mem_s.rd_n;
    assign mem_wr_n = mem_s.wr_n;
    assign per_rd_n = per_s.rd_n;
    assign per_wr_n = per_s.wr_n;
    assign per_reg  = dec.reg_sel;

    always_comb begin
        if (!per_rd_n || !per_wr_n) begin
            assert_strobe_has_select_R1: assert ($countones(~sel_n) == 1)
                else $error("peripheral strobe without a select");
        end
        if (!buf_oe_n) begin
            assert_oe_needs_strobe_R8: assert (!per_rd_n || !per_wr_n)
                else $error("buffer enabled without peripheral strobe");
        end
        if (buf_to_cpu) begin
            assert_dir_measure_R9: assert (!sel_n[FN_MEASURE])
                else $error("buffer toward cpu without measurement select");
        end
    end
endmodule

// File: tb/periph_window_decoder_bench.sv
module periph_window_decoder_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] cpu_addr = 16'h0000;
    logic        cpu_rd_n = 1'b1;
    logic        cpu_wr_n = 1'b1;
    logic        mem_rd_n, mem_wr_n, per_rd_n, per_wr_n;
    logic [3:0]  sel_n;
    logic [1:0]  per_reg;
    logic        buf_oe_n, buf_to_cpu;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    periph_window_decoder u_periph_window_decoder (
        .cpu_addr   (cpu_addr),
        .cpu_rd_n   (cpu_rd_n),
        .cpu_wr_n   (cpu_wr_n),
        .mem_rd_n   (mem_rd_n),
        .mem_wr_n   (mem_wr_n),
        .per_rd_n   (per_rd_n),
        .per_wr_n   (per_wr_n),
        .sel_n      (sel_n),
        .per_reg    (per_reg),
        .buf_oe_n   (buf_oe_n),
        .buf_to_cpu (buf_to_cpu)
    );

    task automatic check(string req, string phase, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s (%s) %s addr=%04h actual=%0h expected=%0h",
                     req, phase, what, cpu_addr, act, exp);
        end
    endtask

    // Drive on the falling edge, judge on the rising edge against the model.
    task automatic apply(string phase, int a, bit rd, bit wr);
        bit in_win;
        int idx;
        @(negedge clk);
        cpu_addr = a[15:0];
        cpu_rd_n = rd;
        cpu_wr_n = wr;
        @(posedge clk);
        in_win = (a >= 15552) && (a <= 15567);
        idx    = in_win ? (a - 15552) / 4 : 0;
        if (in_win) begin
            check("R4", phase, "mem_rd_n", mem_rd_n, 1);
            check("R4", phase, "mem_wr_n", mem_wr_n, 1);
            check("R5", phase, "per_rd_n", per_rd_n, rd);
            check("R5", phase, "per_wr_n", per_wr_n, wr);
            check("R6", phase, "sel_n", sel_n, 15 - (1 << idx));
        end else begin
            check("R3", phase, "mem_rd_n", mem_rd_n, rd);
            check("R3", phase, "mem_wr_n", mem_wr_n, wr);
            check("R5", phase, "per_rd_n", per_rd_n, 1);
            check("R5", phase, "per_wr_n", per_wr_n, 1);
            check("R6", phase, "sel_n", sel_n, 15);
        end
        check("R7", phase, "per_reg", per_reg, a % 4);
        check("R8", phase, "buf_oe_n", buf_oe_n, (in_win && (!rd || !wr)) ? 0 : 1);
        check("R9", phase, "buf_to_cpu", buf_to_cpu, (in_win && idx == 0) ? 1 : 0);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #1;
        check("R3", "reset", "mem_rd_n", mem_rd_n, 1);
        check("R5", "reset", "per_rd_n", per_rd_n, 1);
        check("R6", "reset", "sel_n", sel_n, 15);
        check("R8", "reset", "buf_oe_n", buf_oe_n, 1);
        rst = 1'b0;

        // R1: every window address with each strobe pattern, plus the edges.
        for (int a = 15552; a <= 15567; a++) begin
            for (int s = 0; s < 4; s++) apply("R1", a, s[0], s[1]);
        end
        apply("R1", 15551, 1'b0, 1'b1);
        apply("R1", 15568, 1'b0, 1'b1);
        apply("R1", 15551, 1'b1, 1'b0);
        apply("R1", 15568, 1'b1, 1'b0);

        // R2: single upper-bit inversions of window addresses.
        for (int b = 4; b < 16; b++) begin
            apply("R2", 15552 ^ (1 << b), 1'b0, 1'b1);
            apply("R2", 15567 ^ (1 << b), 1'b1, 1'b0);
        end

        // R10: read and write low together, in and out of the window.
        for (int a = 15552; a <= 15567; a += 3) apply("R10", a, 1'b0, 1'b0);
        apply("R10", 16'h0000, 1'b0, 1'b0);
        apply("R10", 16'hFFFF, 1'b0, 1'b0);

        // Full address sweep with the strobe pattern rotating.
        for (int a = 0; a < 65536; a++) begin
            apply("sweep", a, a[4] ^ a[0], a[5] ^ a[1]);
        end

        done = 1'b1;
    end

    initial begin
        while (!done && cycles < 200000) begin
            @(posedge clk);
            cycles++;
        end
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=done", cycles);
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule